// File: doc/BRIEF.md
# Serial Port Register and Command Controller

This block is the byte-level control plane of a serial port. A host reaches it through a 64-byte register window and uses it to set up the port, issue commands, read status and take interrupts. Bit-level serialisation and baud timing are not part of this block. Received bytes come in from a deserialiser through a valid/ready input with a separate break-event strobe, and they collect in a small receive FIFO. Bytes written for transmission leave through a valid/ready output towards a serialiser. A single active-high interrupt request combines the interrupt sources with a host-written mask.

The two mode registers share one offset and are reached through a pointer. The pointer is a two-state machine: `PTR_MR1` moves to `PTR_MR2` on any read or write of the mode offset. `PTR_MR2` stays where it is until a reset-pointer command returns it to `PTR_MR1`.

The transmit path is a three-state machine. `TX_IDLE` (buffer empty) moves on a buffer write to `TX_SEND` when the transmitter is enabled, and to `TX_HOLD` otherwise. `TX_HOLD` keeps the byte and moves to `TX_SEND` when an enable command arrives. `TX_SEND` offers the byte and returns to `TX_IDLE` when the handshake completes. A reset-transmitter command sends any state back to `TX_IDLE`. A command byte holds three fields: misc in bits [6:4], transmitter in bits [3:2] and receiver in bits [1:0]. They are applied in that order, so a later field wins.

Top module: `sercon_regs`

## Requirements
- R1: After reset the status register (offset 0x04) reads 0x08, with only transmitter-empty set. The interrupt mask is zero, irq is low, rx_ready is low, tx_valid is low, and the mode pointer selects mode register 1.
- R2: A read or write at offset 0x00 reaches the mode register that the pointer selects. The first such access after reset, or after command 0x10 (misc field 1), reaches mode register 1. Every later access reaches mode register 2.
- R3: Interrupt status (read at 0x14) has bit0 transmit, bit1 receive and bit2 break-change, and bits 7:3 read zero. Bit0 equals transmitter-ready. A write at 0x14 sets the mask. irq is high exactly when interrupt status AND mask is non-zero.
- R4: The receive interrupt follows FIFO-full (status bit1) when bit6 of mode register 1 is 1, and follows receiver-ready (status bit0) when that bit is 0.
- R5: With the receiver enabled (receiver field 1, disabled by field 2), rx_ready is high while the FIFO holds fewer than RX_DEPTH bytes. Reads of 0x0C return bytes in arrival order and pop them. Status bit0 means non-empty and bit1 means full. A read of 0x0C on an empty FIFO returns 0x00.
- R6: An rx_break pulse sets interrupt status bit2 and stores a 0x00 byte. It overwrites the newest byte when the FIFO is full. Command 0x50 (misc field 5) clears bit2.
- R7: Command 0x20 (misc field 2) empties the FIFO, clears status bits 0 and 1, and disables the receiver.
- R8: Status bit2 (transmitter-ready) is high exactly when the transmitter is enabled and bit3 (transmitter-empty) is high. A write to 0x0C with the transmitter enabled raises tx_valid with that byte and clears bit3. When tx_ready completes the handshake, tx_valid drops and bit3 returns.
- R9: A byte written to 0x0C while the transmitter is disabled (transmitter field 2) is held with tx_valid low and bit3 clear. A later enable command (transmitter field 1) offers it on tx_valid.
- R10: Command 0x30 (misc field 3) discards any pending byte, sets bit3, disables the transmitter and so clears bit2.
- R11: Field value 3 in the transmitter or receiver field, and misc values 4, 6 and 7, change neither status, interrupt status, nor rx_ready.
- R12: Only address bits [5:0] are decoded, so offset+0x40 aliases offset. Writes to 0x04 and 0x10 are discarded. Reads of unmapped offsets and of 0x08 return 0x00.
- R13: While tx_valid is high, tx_data holds steady, and a write to 0x0C is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (drives read side effects) |
| bus_addr_i | input | ADDR_W | Register byte address; bits [5:0] decoded |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid in the strobe cycle |
| rx_valid_i | input | 1 | Received byte offered |
| rx_data_i | input | 8 | Received byte |
| rx_break_i | input | 1 | Break event strobe |
| rx_ready_o | output | 1 | Receive FIFO can accept a byte |
| tx_valid_o | output | 1 | Transmit byte offered |
| tx_data_o | output | 8 | Transmit byte |
| tx_ready_i | input | 1 | Serialiser accepts the byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every piece of state here shows up at a port no more than one access after it goes wrong. A wrong transmit state shows as a tx_valid that rises without a buffer write or an enable command, or as status bit3 disagreeing with the handshake on the next read. A mis-stepped mode pointer returns the other mode register on the very next 0x00 read. FIFO pointer or count errors show as wrong byte order on 0x0C reads, or as a full flag and rx_ready that disagree with the number of pushes. A stuck break flag or a wrong receive-interrupt source shows on irq in the cycle after the event.

// File: rtl/sercon_pkg.sv
package sercon_pkg;

    localparam int OFS_W = 6;

    localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
    localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_INTR = 6'h14;

    // bit in mode register 1 that picks the receive-interrupt source
    localparam int MR1_RXSRC_BIT = 6;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HOLD = 2'd1,
        TX_SEND = 2'd2
    } tx_state_e;

    typedef enum logic {
        PTR_MR1 = 1'b0,
        PTR_MR2 = 1'b1
    } mr_ptr_e;

    typedef enum logic [2:0] {
        MC_NOP    = 3'd0,
        MC_PTRRST = 3'd1,
        MC_RXRST  = 3'd2,
        MC_TXRST  = 3'd3,
        MC_ERRRST = 3'd4,
        MC_BRKCLR = 3'd5,
        MC_BRKON  = 3'd6,
        MC_BRKOFF = 3'd7
    } misc_cmd_e;

    typedef enum logic [1:0] {
        FLD_KEEP = 2'd0,
        FLD_ON   = 2'd1,
        FLD_OFF  = 2'd2,
        FLD_RSVD = 2'd3
    } en_field_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_t;

endpackage

// File: rtl/sercon_cmd_dec.sv
module sercon_cmd_dec
    import sercon_pkg::*;
(
    input  logic       valid_i,
    input  logic [7:0] byte_i,
    output cmd_t       cmd_o
);

    misc_cmd_e misc;
    en_field_e txf;
    en_field_e rxf;
    logic      unused_bit7;

    assign misc        = misc_cmd_e'(byte_i[6:4]);
    assign txf         = en_field_e'(byte_i[3:2]);
    assign rxf         = en_field_e'(byte_i[1:0]);
    assign unused_bit7 = byte_i[7];

    always_comb begin
        cmd_o = '0;
        if (valid_i) begin
            unique case (misc)
                MC_PTRRST: cmd_o.ptr_rst = 1'b1;
                MC_RXRST:  cmd_o.rx_rst  = 1'b1;
                MC_TXRST:  cmd_o.tx_rst  = 1'b1;
                MC_BRKCLR: cmd_o.brk_clr = 1'b1;
                MC_NOP, MC_ERRRST, MC_BRKON, MC_BRKOFF: ;
            endcase
            unique case (txf)
                FLD_ON:  cmd_o.tx_on  = 1'b1;
                FLD_OFF: cmd_o.tx_off = 1'b1;
                FLD_KEEP, FLD_RSVD: ;
            endcase
            unique case (rxf)
                FLD_ON:  cmd_o.rx_on  = 1'b1;
                FLD_OFF: cmd_o.rx_off = 1'b1;
                FLD_KEEP, FLD_RSVD: ;
            endcase
        end
    end

endmodule

// File: rtl/sercon_tx_fsm.sv
module sercon_tx_fsm
    import sercon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic              tx_ready_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              empty_o
);

    tx_state_e         st_q, st_d;
    logic [DATA_W-1:0] buf_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE: if (load_i)     st_d = en_i ? TX_SEND : TX_HOLD;
            TX_HOLD: if (start_i)    st_d = TX_SEND;
            TX_SEND: if (tx_ready_i) st_d = TX_IDLE;
            default:                 st_d = TX_IDLE;
        endcase
        if (abort_i) st_d = TX_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         buf_q <= '0;
        else if (load_i && st_q != TX_SEND) buf_q <= load_data_i;
    end

    always_comb begin
        tx_valid_o = (st_q == TX_SEND);
        empty_o    = (st_q == TX_IDLE);
        tx_data_o  = buf_q;
    end

    assert_data_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_data_o)))
        else $error("tx byte changed while offered");

    assert_start_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid_o) |-> $past(load_i || start_i))
        else $error("tx_valid rose without load or enable");

    assert_abort_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> empty_o)
        else $error("transmitter reset left a byte pending");

endmodule

// File: rtl/sercon_rx_fifo.sv
module sercon_rx_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              brk_i,
    input  logic              pop_i,
    input  logic              flush_i,
    output logic [DATA_W-1:0] head_o,
    output logic              nonempty_o,
    output logic              full_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;

    logic              do_pop, room, do_push, do_ovw, do_wr;
    logic [PTR_W-1:0]  wr_idx, newest_idx;
    logic [DATA_W-1:0] wr_val;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
    endfunction

    assign do_pop     = pop_i && (cnt_q != '0);
    assign room       = (cnt_q != FULL_CNT) || do_pop;
    assign do_push    = (push_i || brk_i) && room;
    assign do_ovw     = brk_i && !room;
    assign do_wr      = (do_push || do_ovw) && !flush_i;
    assign newest_idx = (wr_ptr_q == '0) ? LAST_IDX : wr_ptr_q - PTR_W'(1);
    assign wr_idx     = do_ovw ? newest_idx : wr_ptr_q;
    assign wr_val     = brk_i ? '0 : data_i;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                           mem_q[i] <= '0;
            else if (do_wr && wr_idx == PTR_W'(i)) mem_q[i] <= wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (do_push) wr_ptr_q <= bump(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
            cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    assign head_o     = (cnt_q != '0) ? mem_q[rd_ptr_q] : '0;
    assign nonempty_o = (cnt_q != '0);
    assign full_o     = (cnt_q == FULL_CNT);

    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !nonempty_o)
        else $error("flush left bytes in FIFO");

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && !pop_i && !flush_i) |=> full_o)
        else $error("full FIFO lost its fill level");

    assert_last_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && pop_i && !push_i && !brk_i && !flush_i) |=> !nonempty_o)
        else $error("FIFO not empty after last pop");

endmodule

// File: rtl/sercon_regs.sv
module sercon_regs
    import sercon_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [7:0]        bus_wdata_i,
    output logic [7:0]        bus_rdata_o,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              rx_break_i,
    output logic              rx_ready_o,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    input  logic              tx_ready_i,
    output logic              irq_o
);

    logic [OFS_W-1:0] ofs;
    logic             hit_mode, hit_cmd, hit_data, hit_intr;
    cmd_t             cmd;
    mr_ptr_e          ptr_q, ptr_d;
    logic [7:0]       mr1_q, mr2_q, imr_q;
    logic             tx_en_q, rx_en_q, brk_q;
    logic             tx_empty, tx_rdy, rx_full, rx_any, rx_int;
    logic [7:0]       fifo_head, stat, isr;
    logic             unused_hi;

    assign ofs       = bus_addr_i[OFS_W-1:0];
    assign unused_hi = ^bus_addr_i;
    assign hit_mode  = (ofs == OFS_MODE);
    assign hit_cmd   = (ofs == OFS_CMD);
    assign hit_data  = (ofs == OFS_DATA);
    assign hit_intr  = (ofs == OFS_INTR);

    sercon_cmd_dec u_dec (
        .valid_i (bus_wr_i && hit_cmd),
        .byte_i  (bus_wdata_i),
        .cmd_o   (cmd)
    );

    // mode-register pointer state machine
    always_comb begin
        ptr_d = ptr_q;
        unique case (ptr_q)
            PTR_MR1: if ((bus_wr_i || bus_rd_i) && hit_mode) ptr_d = PTR_MR2;
            PTR_MR2: ;
        endcase
        if (cmd.ptr_rst) ptr_d = PTR_MR1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= PTR_MR1;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr1_q <= '0;
            mr2_q <= '0;
            imr_q <= '0;
        end else if (bus_wr_i) begin
            if (hit_mode && ptr_q == PTR_MR1) mr1_q <= bus_wdata_i;
            if (hit_mode && ptr_q == PTR_MR2) mr2_q <= bus_wdata_i;
            if (hit_intr)                     imr_q <= bus_wdata_i;
        end
    end

    // enables: misc reset first, then the enable fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            rx_en_q <= 1'b0;
        end else begin
            if (cmd.tx_on)                       tx_en_q <= 1'b1;
            else if (cmd.tx_off || cmd.tx_rst)   tx_en_q <= 1'b0;
            if (cmd.rx_on)                       rx_en_q <= 1'b1;
            else if (cmd.rx_off || cmd.rx_rst)   rx_en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          brk_q <= 1'b0;
        else if (rx_break_i) brk_q <= 1'b1;
        else if (cmd.brk_clr) brk_q <= 1'b0;
    end

    sercon_tx_fsm #(.DATA_W(8)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (bus_wr_i && hit_data),
        .load_data_i (bus_wdata_i),
        .en_i        (tx_en_q),
        .start_i     (cmd.tx_on),
        .abort_i     (cmd.tx_rst),
        .tx_ready_i  (tx_ready_i),
        .tx_valid_o  (tx_valid_o),
        .tx_data_o   (tx_data_o),
        .empty_o     (tx_empty)
    );

    assign rx_ready_o = rx_en_q && !rx_full && !rx_break_i;

    sercon_rx_fifo #(.DEPTH(RX_DEPTH), .DATA_W(8)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (rx_valid_i && rx_ready_o),
        .data_i     (rx_data_i),
        .brk_i      (rx_break_i),
        .pop_i      (bus_rd_i && hit_data),
        .flush_i    (cmd.rx_rst),
        .head_o     (fifo_head),
        .nonempty_o (rx_any),
        .full_o     (rx_full)
    );

    assign tx_rdy = tx_en_q && tx_empty;
    assign rx_int = mr1_q[MR1_RXSRC_BIT] ? rx_full : rx_any;
    assign stat   = {4'b0000, tx_empty, tx_rdy, rx_full, rx_any};
    assign isr    = {5'b00000, brk_q, rx_int, tx_rdy};
    assign irq_o  = |(isr & imr_q);

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            case (ofs)
                OFS_MODE: bus_rdata_o = (ptr_q == PTR_MR1) ? mr1_q : mr2_q;
                OFS_STAT: bus_rdata_o = stat;
                OFS_DATA: bus_rdata_o = fifo_head;
                OFS_INTR: bus_rdata_o = isr;
                default:  bus_rdata_o = '0;
            endcase
        end
    end

    assert_ptr_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == PTR_MR2 && !cmd.ptr_rst) |=> (ptr_q == PTR_MR2))
        else $error("mode pointer left MR2 without command");

    assert_rx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready_o |-> (rx_en_q && !rx_full))
        else $error("rx_ready while disabled or full");

    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (imr_q != 8'h00))
        else $error("irq with empty mask");

    assert_brk_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_break_i |=> brk_q)
        else $error("break event not latched");

    assert_txrst_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.tx_rst && !cmd.tx_on) |=> (!tx_rdy && tx_empty))
        else $error("transmitter reset left it ready or busy");

endmodule

// File: tb/sercon_regs_tb.sv
`timescale 1ns/1ps
module sercon_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
    logic       rx_valid = 1'b0, rx_break = 1'b0, rx_ready;
    logic [7:0] rx_data = '0;
    logic       tx_valid, tx_ready = 1'b0, irq;
    logic [7:0] tx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    sercon_regs #(.ADDR_W(8), .RX_DEPTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_break_i(rx_break),
        .rx_ready_o(rx_ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
        .tx_ready_i(tx_ready), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; #1; d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic brk();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
    endtask

    task automatic handshake();
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h04, v); chk("R1 status", v, 8'h08);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
        rd(8'h14, v); chk("R1 isr", v, 8'h00);
    endtask

    task automatic t_mode_ptr();
        logic [7:0] v;
        wr(8'h00, 8'h4A);
        wr(8'h00, 8'h13);
        rd(8'h00, v); chk("R2 mr2 read", v, 8'h13);
        rd(8'h00, v); chk("R2 mr2 sticky", v, 8'h13);
        wr(8'h08, 8'h10);
        rd(8'h00, v); chk("R1 R2 mr1 after ptr reset", v, 8'h4A);
        rd(8'h00, v); chk("R2 back on mr2", v, 8'h13);
        wr(8'h08, 8'h10);
        wr(8'h00, 8'h00);
    endtask

    task automatic t_tx_send();
        logic [7:0] v;
        wr(8'h14, 8'h01);
        wr(8'h08, 8'h04);
        rd(8'h04, v); chk("R8 status enabled idle", v, 8'h0C);
        chk("R3 irq tx", {7'd0, irq}, 8'h01);
        wr(8'h0C, 8'hA5);
        chk("R8 tx_valid", {7'd0, tx_valid}, 8'h01);
        chk("R8 tx_data", tx_data, 8'hA5);
        rd(8'h04, v); chk("R8 status busy", v, 8'h00);
        chk("R3 irq drops", {7'd0, irq}, 8'h00);
        wr(8'h0C, 8'h11);
        chk("R13 write dropped", tx_data, 8'hA5);
        chk("R13 still valid", {7'd0, tx_valid}, 8'h01);
        handshake();
        chk("R8 valid after handshake", {7'd0, tx_valid}, 8'h00);
        rd(8'h04, v); chk("R8 status after handshake", v, 8'h0C);
    endtask

    task automatic t_tx_hold();
        logic [7:0] v;
        wr(8'h08, 8'h08);
        rd(8'h04, v); chk("R8 disabled status", v, 8'h08);
        wr(8'h0C, 8'h5A);
        chk("R9 held no valid", {7'd0, tx_valid}, 8'h00);
        rd(8'h04, v); chk("R9 held status", v, 8'h00);
        wr(8'h08, 8'h04);
        chk("R9 enable offers", {7'd0, tx_valid}, 8'h01);
        chk("R9 held data", tx_data, 8'h5A);
        handshake();
        wr(8'h08, 8'h08);
        wr(8'h0C, 8'h77);
        wr(8'h08, 8'h30);
        rd(8'h04, v); chk("R10 status after tx reset", v, 8'h08);
        wr(8'h08, 8'h04);
        chk("R10 byte discarded", {7'd0, tx_valid}, 8'h00);
        rd(8'h04, v); chk("R10 re-enabled", v, 8'h0C);
    endtask

    task automatic t_rx_fifo();
        logic [7:0] v;
        chk("R5 rx_ready disabled", {7'd0, rx_ready}, 8'h00);
        wr(8'h08, 8'h01);
        chk("R5 rx_ready enabled", {7'd0, rx_ready}, 8'h01);
        for (int i = 0; i < 4; i++) push(8'h31 + 8'(i));
        rd(8'h04, v); chk("R5 full status", v, 8'h0F);
        chk("R5 rx_ready full", {7'd0, rx_ready}, 8'h00);
        rd(8'h0C, v); chk("R5 first byte", v, 8'h31);
        rd(8'h04, v); chk("R5 after pop", v, 8'h0D);
        for (int i = 1; i < 4; i++) begin
            rd(8'h0C, v); chk("R5 order", v, 8'h31 + 8'(i));
        end
        rd(8'h04, v); chk("R5 empty status", v, 8'h0C);
        rd(8'h0C, v); chk("R5 empty read", v, 8'h00);
    endtask

    task automatic t_rx_irq();
        logic [7:0] v;
        wr(8'h14, 8'h02);
        push(8'h21);
        rd(8'h14, v); chk("R3 R4 isr ready source", v, 8'h03);
        chk("R4 irq on ready", {7'd0, irq}, 8'h01);
        wr(8'h08, 8'h10);
        wr(8'h00, 8'h40);
        chk("R4 irq full source", {7'd0, irq}, 8'h00);
        for (int i = 0; i < 3; i++) push(8'h22 + 8'(i));
        chk("R4 irq on full", {7'd0, irq}, 8'h01);
        wr(8'h08, 8'h20);
        rd(8'h04, v); chk("R7 status after rx reset", v, 8'h0C);
        chk("R7 rx disabled", {7'd0, rx_ready}, 8'h00);
        chk("R7 irq cleared", {7'd0, irq}, 8'h00);
        wr(8'h08, 8'h10);
        wr(8'h00, 8'h00);
    endtask

    task automatic t_break();
        logic [7:0] v;
        wr(8'h08, 8'h01);
        wr(8'h14, 8'h04);
        brk();
        rd(8'h14, v); chk("R6 isr break", v, 8'h07);
        chk("R6 irq", {7'd0, irq}, 8'h01);
        for (int i = 1; i < 4; i++) push(8'(i));
        brk();
        wr(8'h08, 8'h50);
        chk("R6 break cleared", {7'd0, irq}, 8'h00);
        rd(8'h0C, v); chk("R6 byte0", v, 8'h00);
        rd(8'h0C, v); chk("R6 byte1", v, 8'h01);
        rd(8'h0C, v); chk("R6 byte2", v, 8'h02);
        rd(8'h0C, v); chk("R6 overwritten", v, 8'h00);
    endtask

    task automatic t_misc();
        logic [7:0] v;
        wr(8'h08, 8'h0F);
        chk("R11 rsvd rx", {7'd0, rx_ready}, 8'h01);
        rd(8'h04, v); chk("R11 rsvd tx", v, 8'h0C);
        wr(8'h08, 8'h40);
        wr(8'h08, 8'h60);
        wr(8'h08, 8'h70);
        rd(8'h04, v); chk("R11 misc status", v, 8'h0C);
        rd(8'h14, v); chk("R11 misc isr", v, 8'h01);
        chk("R11 misc rx_ready", {7'd0, rx_ready}, 8'h01);
    endtask

    task automatic t_alias();
        logic [7:0] v;
        wr(8'h54, 8'h01);
        chk("R12 alias mask", {7'd0, irq}, 8'h01);
        rd(8'h44, v); chk("R12 alias status", v, 8'h0C);
        wr(8'h04, 8'hFF);
        wr(8'h10, 8'hFF);
        rd(8'h04, v); chk("R12 discarded writes", v, 8'h0C);
        rd(8'h18, v); chk("R12 unmapped", v, 8'h00);
        rd(8'h08, v); chk("R12 cmd read", v, 8'h00);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mode_ptr();
        t_tx_send();
        t_tx_hold();
        t_rx_fifo();
        t_rx_irq();
        t_break();
        t_misc();
        t_alias();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule